// File: doc/BRIEF.md
# Engine Execution Control Port

This block is the host-side control port of a small embedded processing engine. A host reaches it over a simple register bus with a word-wide write strobe and a combinational read path. Behind the port sit three storage spaces that share one access method: the engine's instruction memory, its data memory and a small file of execution-context registers. To write into one of them, the host loads a data word, then an address word, then issues a command. To read, it loads an address, issues a read command and collects the result from the data register two cycles later.

The same command register also runs the engine. It can start and stop continuous running, single-step while halted, mark the pipeline as flushed and zero a profiling counter. Reading the command register returns a status word. The engine core is a stub: it completes one instruction per clock while it runs, and one per step command while it is halted. Each completed instruction advances a watch counter, and a host that issues a step learns that the step finished by seeing that counter move.

Top module: `eng_exec_ctl`

## Requirements
- R1: After reset, the status word reads 0x40800000 (halted, pipeline clean). The watch counter, the profile counter, the data register and the address register all read 0.
- R2: Bus register index 0 is the data register, 1 the address register, 2 command (on write) and status (on read), 3 the watch counter and 4 the profile counter. The data and address registers read back the last value written. Indexes 5 to 7 read 0.
- R3: The command is taken from bits 7:0 of the word written to index 2. A code outside the defined set changes no status bit and no counter.
- R4: Code 0x02 (start) sets status bit 31 (running) and clears bit 30 (halted), effective from the clock edge that takes the command. Code 0x03 (stop) clears bit 31 and sets bit 30 at that same edge.
- R5: Code 0x01 (step) while halted adds exactly one to the watch counter at the edge that takes it. While running, a step has no effect.
- R6: While running, the watch counter and the profile counter each advance by one on every clock edge, including the edge that takes a stop. While halted, neither advances except through a step.
- R7: Code 0x04 (flush) sets status bit 29 (flushed) and bit 23 (pipeline clean). A start, or a step accepted while halted, clears both bits.
- R8: Code 0x0C zeroes the profile counter and leaves the watch counter unchanged.
- R9: Codes 0x11, 0x13 and 0x15 write the data register into the instruction memory, the data memory and the context file at the address register. A memory is indexed by the low address bits and wraps modulo its depth. The context file is indexed by address bits 4:0.
- R10: Codes 0x10, 0x12 and 0x14 read the instruction memory, the data memory and the context file into the data register. The data register holds its old value for the two edges after the command and shows the result from the third bus cycle on.
- R11: The context file has three registers at offsets +0, +1 and +2 of each of four levels based at 0x00, 0x04, 0x08 and 0x0C, plus one at 0x11. Reset values: level 0x00 holds A0000000/01000000/00008000, levels 0x04 and 0x08 hold 20000080/01000000/00008000, level 0x0C holds 20000000/00000000/001E0000, and 0x11 holds 1003C00F. Any other offset reads 0, and a write to it changes nothing.
- R12: The instruction memory and the data memory are separate: writing one at some index leaves the other's word at that index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per asserted cycle |
| bus_addr | input | 3 | Register index for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the index |

## Verification
The assertions assume that the host is well behaved. It does not rewrite the address register, and it issues no second read command, while a read is still travelling through its two pipeline stages. It also never needs more than a counter width of cycles between a start and the next look at the counters. The bench keeps to these rules because every bus action takes a full cycle: after each read command it makes two stale-value checks before the result check, so the bus does nothing else until the result has landed. The bench reads the watch and profile counters only while the engine is halted, and it derives its expected run length from its own count of clock edges between the start and stop commands.

// File: rtl/eng_ctl_pkg.sv
package eng_ctl_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned CTX_N      = 13;
    localparam int unsigned CTX_OFF_W  = 5;
    localparam int unsigned CTX_IDX_W  = $clog2(CTX_N);

    // status word bit positions
    localparam int unsigned ST_RUN_BIT   = 31;
    localparam int unsigned ST_HALT_BIT  = 30;
    localparam int unsigned ST_FLUSH_BIT = 29;
    localparam int unsigned ST_CLEAN_BIT = 23;

    typedef enum logic [7:0] {
        OP_STEP     = 8'h01,
        OP_START    = 8'h02,
        OP_STOP     = 8'h03,
        OP_FLUSH    = 8'h04,
        OP_PROF_CLR = 8'h0C,
        OP_IM_RD    = 8'h10,
        OP_IM_WR    = 8'h11,
        OP_DM_RD    = 8'h12,
        OP_DM_WR    = 8'h13,
        OP_CX_RD    = 8'h14,
        OP_CX_WR    = 8'h15
    } eng_op_e;

    typedef enum logic [2:0] {
        RS_DATA  = 3'd0,
        RS_ADDR  = 3'd1,
        RS_CMD   = 3'd2,
        RS_WATCH = 3'd3,
        RS_PROF  = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_IM = 2'd0,
        SRC_DM = 2'd1,
        SRC_CX = 2'd2
    } rd_src_e;

    // offset 0x11 plus three words in each 4-word level below 0x10
    function automatic logic ctx_mapped(input logic [CTX_OFF_W-1:0] off);
        return (off == 5'h11) || (!off[4] && (off[1:0] != 2'b11));
    endfunction

    function automatic logic [CTX_IDX_W-1:0] ctx_index(input logic [CTX_OFF_W-1:0] off);
        if (off == 5'h11)
            return CTX_IDX_W'(CTX_N - 1);
        return CTX_IDX_W'(off[3:2]) * CTX_IDX_W'(3) + CTX_IDX_W'(off[1:0]);
    endfunction

    function automatic logic [WORD_W-1:0] ctx_reset(input int unsigned idx);
        case (idx)
            0:          return 32'hA000_0000;
            3, 6:       return 32'h2000_0080;
            9:          return 32'h2000_0000;
            1, 4, 7:    return 32'h0100_0000;
            2, 5, 8:    return 32'h0000_8000;
            11:         return 32'h001E_0000;
            12:         return 32'h1003_C00F;
            default:    return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/eng_ram.sv
module eng_ram #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en)
            rd_d = mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/eng_ctx_file.sv
module eng_ctx_file
    import eng_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CTX_OFF_W-1:0] wr_off,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [CTX_OFF_W-1:0] rd_off,
    output logic [WORD_W-1:0]    rd_data
);

    typedef struct packed {
        logic [CTX_N-1:0][WORD_W-1:0] regs;
        logic [WORD_W-1:0]            rd;
    } ctx_state_t;

    ctx_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en && ctx_mapped(wr_off))
            state_d.regs[ctx_index(wr_off)] = wr_data;
        if (rd_en)
            state_d.rd = ctx_mapped(rd_off) ? state_q.regs[ctx_index(rd_off)] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CTX_N; i++)
                state_q.regs[i] <= ctx_reset(i);
            state_q.rd <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = state_q.rd;

    // R11: a write to a hole in the map leaves every register as it was
    assert_hole_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctx_mapped(wr_off)) |=> $stable(state_q.regs));

endmodule

// File: rtl/eng_core_stub.sv
module eng_core_stub #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_step,
    input  logic             op_start,
    input  logic             op_stop,
    input  logic             op_flush,
    input  logic             op_prof_clr,
    output logic             run_o,
    output logic             halt_o,
    output logic             flushed_o,
    output logic             clean_o,
    output logic [CNT_W-1:0] watch_o,
    output logic [CNT_W-1:0] prof_o
);

    typedef struct packed {
        logic             run;
        logic             halt;
        logic             flushed;
        logic             clean;
        logic [CNT_W-1:0] watch;
        logic [CNT_W-1:0] prof;
    } core_state_t;

    core_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.run) begin
            state_d.watch = state_q.watch + CNT_W'(1);
            state_d.prof  = state_q.prof + CNT_W'(1);
        end else if (op_step) begin
            state_d.watch   = state_q.watch + CNT_W'(1);
            state_d.flushed = 1'b0;
            state_d.clean   = 1'b0;
        end
        if (op_start) begin
            state_d.run     = 1'b1;
            state_d.halt    = 1'b0;
            state_d.flushed = 1'b0;
            state_d.clean   = 1'b0;
        end
        if (op_stop) begin
            state_d.run  = 1'b0;
            state_d.halt = 1'b1;
        end
        if (op_flush) begin
            state_d.flushed = 1'b1;
            state_d.clean   = 1'b1;
        end
        if (op_prof_clr)
            state_d.prof = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.run     <= 1'b0;
            state_q.halt    <= 1'b1;
            state_q.flushed <= 1'b0;
            state_q.clean   <= 1'b1;
            state_q.watch   <= '0;
            state_q.prof    <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign run_o     = state_q.run;
    assign halt_o    = state_q.halt;
    assign flushed_o = state_q.flushed;
    assign clean_o   = state_q.clean;
    assign watch_o   = state_q.watch;
    assign prof_o    = state_q.prof;

    assert_stop_clears_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_stop |=> (!state_q.run && state_q.halt));

    assert_start_sets_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !op_stop) |=> (state_q.run && !state_q.halt));

    assert_idle_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.run && op_step) |=> (state_q.watch == $past(state_q.watch) + CNT_W'(1)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.run && !op_step) |=> $stable(state_q.watch));

    assert_run_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.run |=> (state_q.watch == $past(state_q.watch) + CNT_W'(1)));

    assert_prof_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_prof_clr |=> (state_q.prof == '0));

endmodule

// File: rtl/eng_exec_ctl.sv
module eng_exec_ctl
    import eng_ctl_pkg::*;
#(
    parameter int unsigned IMEM_DEPTH = 64,
    parameter int unsigned DMEM_DEPTH = 32,
    parameter int unsigned CNT_W      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    localparam int unsigned IM_AW = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1;
    localparam int unsigned DM_AW = (DMEM_DEPTH > 1) ? $clog2(DMEM_DEPTH) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] addr;
        logic              rd_p1;
        logic              rd_p2;
        rd_src_e           src;
    } port_state_t;

    port_state_t state_d, state_q;

    // command decode
    logic       cmd_wr, data_wr, addr_wr;
    logic [7:0] op;
    logic op_step, op_start, op_stop, op_flush, op_prof_clr;
    logic op_im_rd, op_im_wr, op_dm_rd, op_dm_wr, op_cx_rd, op_cx_wr, rd_start;

    assign cmd_wr  = bus_wr && (bus_addr == RS_CMD);
    assign data_wr = bus_wr && (bus_addr == RS_DATA);
    assign addr_wr = bus_wr && (bus_addr == RS_ADDR);
    assign op      = bus_wdata[7:0];

    assign op_step     = cmd_wr && (op == OP_STEP);
    assign op_start    = cmd_wr && (op == OP_START);
    assign op_stop     = cmd_wr && (op == OP_STOP);
    assign op_flush    = cmd_wr && (op == OP_FLUSH);
    assign op_prof_clr = cmd_wr && (op == OP_PROF_CLR);
    assign op_im_rd    = cmd_wr && (op == OP_IM_RD);
    assign op_im_wr    = cmd_wr && (op == OP_IM_WR);
    assign op_dm_rd    = cmd_wr && (op == OP_DM_RD);
    assign op_dm_wr    = cmd_wr && (op == OP_DM_WR);
    assign op_cx_rd    = cmd_wr && (op == OP_CX_RD);
    assign op_cx_wr    = cmd_wr && (op == OP_CX_WR);
    assign rd_start    = op_im_rd || op_dm_rd || op_cx_rd;

    // storage spaces
    logic [WORD_W-1:0] im_rdata, dm_rdata, cx_rdata, rd_mux;

    eng_ram #(.DEPTH(IMEM_DEPTH), .WIDTH(WORD_W)) imem_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op_im_wr),
        .wr_idx  (state_q.addr[IM_AW-1:0]),
        .wr_data (state_q.data),
        .rd_en   (state_q.rd_p1 && (state_q.src == SRC_IM)),
        .rd_idx  (state_q.addr[IM_AW-1:0]),
        .rd_data (im_rdata)
    );

    eng_ram #(.DEPTH(DMEM_DEPTH), .WIDTH(WORD_W)) dmem_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op_dm_wr),
        .wr_idx  (state_q.addr[DM_AW-1:0]),
        .wr_data (state_q.data),
        .rd_en   (state_q.rd_p1 && (state_q.src == SRC_DM)),
        .rd_idx  (state_q.addr[DM_AW-1:0]),
        .rd_data (dm_rdata)
    );

    eng_ctx_file ctx_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (op_cx_wr),
        .wr_off  (state_q.addr[CTX_OFF_W-1:0]),
        .wr_data (state_q.data),
        .rd_en   (state_q.rd_p1 && (state_q.src == SRC_CX)),
        .rd_off  (state_q.addr[CTX_OFF_W-1:0]),
        .rd_data (cx_rdata)
    );

    // engine stub
    logic             run_s, halt_s, flushed_s, clean_s;
    logic [CNT_W-1:0] watch_s, prof_s;

    eng_core_stub #(.CNT_W(CNT_W)) core_u (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_step     (op_step),
        .op_start    (op_start),
        .op_stop     (op_stop),
        .op_flush    (op_flush),
        .op_prof_clr (op_prof_clr),
        .run_o       (run_s),
        .halt_o      (halt_s),
        .flushed_o   (flushed_s),
        .clean_o     (clean_s),
        .watch_o     (watch_s),
        .prof_o      (prof_s)
    );

    always_comb begin
        case (state_q.src)
            SRC_IM:  rd_mux = im_rdata;
            SRC_DM:  rd_mux = dm_rdata;
            default: rd_mux = cx_rdata;
        endcase
    end

    always_comb begin
        state_d       = state_q;
        state_d.rd_p1 = 1'b0;
        state_d.rd_p2 = state_q.rd_p1;
        if (data_wr)
            state_d.data = bus_wdata;
        if (addr_wr)
            state_d.addr = bus_wdata;
        if (rd_start) begin
            state_d.rd_p1 = 1'b1;
            if (op_im_rd)
                state_d.src = SRC_IM;
            else if (op_dm_rd)
                state_d.src = SRC_DM;
            else
                state_d.src = SRC_CX;
        end
        // a landing read result wins over a host write in the same cycle
        if (state_q.rd_p2)
            state_d.data = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.data  <= '0;
            state_q.addr  <= '0;
            state_q.rd_p1 <= 1'b0;
            state_q.rd_p2 <= 1'b0;
            state_q.src   <= SRC_IM;
        end else begin
            state_q <= state_d;
        end
    end

    logic [WORD_W-1:0] status_w;
    always_comb begin
        status_w               = '0;
        status_w[ST_RUN_BIT]   = run_s;
        status_w[ST_HALT_BIT]  = halt_s;
        status_w[ST_FLUSH_BIT] = flushed_s;
        status_w[ST_CLEAN_BIT] = clean_s;
    end

    always_comb begin
        case (bus_addr)
            RS_DATA:  bus_rdata = state_q.data;
            RS_ADDR:  bus_rdata = state_q.addr;
            RS_CMD:   bus_rdata = status_w;
            RS_WATCH: bus_rdata = 32'(watch_s);
            RS_PROF:  bus_rdata = 32'(prof_s);
            default:  bus_rdata = '0;
        endcase
    end

    logic unused_addr_bits;
    assign unused_addr_bits = ^state_q.addr;

    // R10: the data register keeps its old value through both read stages
    assert_rd_stale_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !data_wr && !state_q.rd_p2) |=> $stable(state_q.data));

    assert_rd_stale_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.rd_p1 && !data_wr && !state_q.rd_p2) |=> $stable(state_q.data));

endmodule

// File: tb/eng_exec_ctl_tb_top.sv
module eng_exec_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    always #10 clk = ~clk;   // 50 MHz

    eng_exec_ctl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    typedef struct {
        logic [2:0]  a;
        logic [31:0] v;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    event item_ev;
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done   = 1'b0;
    int unsigned exp_watch = 0;
    int unsigned exp_prof  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each queued expectation away from the clock edge
    initial begin
        forever begin
            @(item_ev);
            #2;
            while (sb_q.size() != 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (bus_rdata !== it.v) begin
                    fails++;
                    $display("FAIL %s: reg %0d actual %h expected %h", it.tag, it.a, bus_rdata, it.v);
                end
            end
        end
    end

    // driver tasks start and end at a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [31:0] v);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = v;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] v, input string tag);
        exp_t it;
        bus_addr = a;
        it.a = a;
        it.v = v;
        it.tag = tag;
        sb_q.push_back(it);
        -> item_ev;
        @(negedge clk);
    endtask

    task automatic mem_read(input logic [7:0] code, input logic [31:0] adr,
                            input logic [31:0] stale, input logic [31:0] v, input string tag);
        bus_write(3'd0, stale);
        bus_write(3'd1, adr);
        bus_write(3'd2, {24'h0, code});
        expect_reg(3'd0, stale, {tag, " stale 1 R10"});
        expect_reg(3'd0, stale, {tag, " stale 2 R10"});
        expect_reg(3'd0, v, tag);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        int t1;
        rst_n     = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = 3'd0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        expect_reg(3'd2, 32'h4080_0000, "R1 status after reset");
        expect_reg(3'd3, 32'h0, "R1 watch after reset");
        expect_reg(3'd4, 32'h0, "R1 profile after reset");
        expect_reg(3'd0, 32'h0, "R1 data after reset");
        expect_reg(3'd1, 32'h0, "R1 address after reset");

        // register map
        bus_write(3'd0, 32'hCAFE_0001);
        bus_write(3'd1, 32'h0000_0025);
        expect_reg(3'd0, 32'hCAFE_0001, "R2 data readback");
        expect_reg(3'd1, 32'h0000_0025, "R2 address readback");
        expect_reg(3'd5, 32'h0, "R2 index 5 reads zero");
        expect_reg(3'd7, 32'h0, "R2 index 7 reads zero");

        // unknown code
        bus_write(3'd2, 32'h0000_0007);
        expect_reg(3'd2, 32'h4080_0000, "R3 unknown code status");
        expect_reg(3'd3, 32'h0, "R3 unknown code watch");

        // flush, then step while halted
        bus_write(3'd2, 32'h0000_0004);
        expect_reg(3'd2, 32'h6080_0000, "R7 flush sets bits");
        bus_write(3'd2, 32'h0000_0001);
        exp_watch = exp_watch + 1;
        expect_reg(3'd3, exp_watch, "R5 step while halted");
        expect_reg(3'd2, 32'h4000_0000, "R7 step clears flush bits");
        expect_reg(3'd4, 32'h0, "R6 profile idle while halted");
        bus_write(3'd2, 32'h0000_0004);
        expect_reg(3'd2, 32'h6080_0000, "R7 flush again");

        // run, step ignored while running, stop
        bus_write(3'd2, 32'h0000_0002);
        t0 = cyc;
        expect_reg(3'd2, 32'h8000_0000, "R4 running after start");
        repeat (4) @(negedge clk);
        bus_write(3'd2, 32'h0000_0001);   // R5 step while running is ignored
        repeat (3) @(negedge clk);
        bus_write(3'd2, 32'h0000_0003);
        t1 = cyc;
        exp_watch = exp_watch + (t1 - t0);
        exp_prof  = exp_prof + (t1 - t0);
        expect_reg(3'd2, 32'h4000_0000, "R4 halted after stop");
        expect_reg(3'd3, exp_watch, "R6 watch over run (R5 step ignored)");
        expect_reg(3'd4, exp_prof, "R6 profile over run");
        expect_reg(3'd3, exp_watch, "R6 watch holds when halted");

        // profile clear
        bus_write(3'd2, 32'h0000_000C);
        exp_prof = 0;
        expect_reg(3'd4, 32'h0, "R8 profile cleared");
        expect_reg(3'd3, exp_watch, "R8 watch untouched");

        // memory writes and reads
        bus_write(3'd0, 32'hDEAD_BEEF);
        bus_write(3'd1, 32'd5);
        bus_write(3'd2, 32'h0000_0011);
        bus_write(3'd0, 32'h1234_5678);
        bus_write(3'd2, 32'h0000_0013);
        mem_read(8'h10, 32'd5, 32'h0, 32'hDEAD_BEEF, "R9 instruction word");
        mem_read(8'h12, 32'd5, 32'h0, 32'h1234_5678, "R12 data word separate");
        mem_read(8'h12, 32'd37, 32'h0, 32'h1234_5678, "R9 data index wraps");
        mem_read(8'h10, 32'd69, 32'h0, 32'hDEAD_BEEF, "R9 instruction index wraps");

        // context file
        mem_read(8'h14, 32'h00, 32'h5A5A_5A5A, 32'hA000_0000, "R11 background reg0");
        mem_read(8'h14, 32'h04, 32'h5A5A_5A5A, 32'h2000_0080, "R11 pri1 reg0");
        mem_read(8'h14, 32'h0A, 32'h5A5A_5A5A, 32'h0000_8000, "R11 pri2 reg2");
        mem_read(8'h14, 32'h0E, 32'h5A5A_5A5A, 32'h001E_0000, "R11 debug reg2");
        mem_read(8'h14, 32'h11, 32'h5A5A_5A5A, 32'h1003_C00F, "R11 instruction reg");
        mem_read(8'h14, 32'h03, 32'h5A5A_5A5A, 32'h0, "R11 hole reads zero");
        mem_read(8'h14, 32'h10, 32'h5A5A_5A5A, 32'h0, "R11 hole 0x10 reads zero");
        bus_write(3'd0, 32'h000A_0003);
        bus_write(3'd1, 32'h05);
        bus_write(3'd2, 32'h0000_0015);
        mem_read(8'h14, 32'h05, 32'h5A5A_5A5A, 32'h000A_0003, "R9 context write");
        bus_write(3'd0, 32'hFFFF_FFFF);
        bus_write(3'd1, 32'h07);
        bus_write(3'd2, 32'h0000_0015);
        mem_read(8'h14, 32'h07, 32'h5A5A_5A5A, 32'h0, "R11 hole write ignored");
        mem_read(8'h14, 32'h08, 32'h5A5A_5A5A, 32'h2000_0080, "R11 neighbour after hole write");
        mem_read(8'h14, 32'h06, 32'h5A5A_5A5A, 32'h0000_8000, "R11 lower neighbour intact");

        @(negedge clk);
        #5;
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule